// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one memory burst. A start pulse captures a start column, a three-bit length code and an ordering bit. From the next clock onward the block presents one column address per beat. It advances to the next beat on each clock where the step enable is high. It marks the final beat of a fixed-length burst and drops its valid output after that beat has been consumed.

Two orderings are supported. In sequential ordering the address counts upward and wraps inside the burst-aligned block. In interleaved ordering the low address bits are the start bits XOR the beat index. A page mode, legal only with sequential ordering, walks the whole 256-column row modulo 256 and runs until a stop input ends it. Length codes with no defined meaning still produce a burst. That burst is a single beat at the start column, and an error flag is raised for it.

A new start always restarts the sequence, including in the middle of a running burst. Starts may come on back-to-back clocks. The block only generates addresses. Data, masking and command decoding are handled elsewhere.

Top module: `colseq_top`

## Requirements
- R1: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 beats. last_o is high on the final beat only, and valid_o is low in the clock after that beat has been stepped.
- R2: With ordering_i = 0 and a burst of L = 2^k beats, beat b has its low k bits equal to (start + b) mod L. Example: L = 8 from column 3 gives 3,4,5,6,7,0,1,2.
- R3: With ordering_i = 1 and a burst of L = 2^k beats, beat b has its low k bits equal to (start low bits) XOR b. Example: L = 8 from column 5 gives 5,4,7,6,1,0,3,2.
- R4: For fixed-length bursts, every column bit at position k and above equals the corresponding bit of the start column.
- R5: Length code 3'b111 with ordering_i = 0 selects page mode. Beat b is (start + b) mod 256. The burst never ends by itself, and last_o is never high in this mode.
- R6: Codes 3'b100, 3'b101 and 3'b110 with either ordering, and code 3'b111 with ordering_i = 1, are reserved. Such a burst has one beat at the start column with last_o high, and err_o is high while it is valid.
- R7: After a clock edge with start_i high, valid_o is high and col_o equals the start column, whether or not a burst was already running.
- R8: While step_i is low, a running burst holds its beat and col_o stays unchanged.
- R9: A clock edge with stop_i high and start_i low ends the burst, so valid_o is low afterwards. If start_i and stop_i are both high, the start takes effect.
- R10: During and right after reset, valid_o, last_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Load a new burst (restarts any running one) |
| start_col_i | input | 8 | Start column for the burst |
| len_code_i | input | 3 | Burst length code |
| ordering_i | input | 1 | 0 sequential, 1 interleaved |
| step_i | input | 1 | Advance one beat at this edge |
| stop_i | input | 1 | End the running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A burst beat is being presented |
| last_o | output | 1 | Current beat is the final one of a fixed burst |
| err_o | output | 1 | Current burst was started with a reserved code |

## Verification
The bench sweeps every start column against every length code under both orderings. This separates wrap-within-block from plain counting, and XOR from increment: both differ from each other only for start columns not aligned to the burst block. Page mode is run from every start column for a short stretch, and once for a long run that crosses column 255 back to 0. That run shows wrap modulo the row and the absence of last_o. Directed patterns then cover a restart in the middle of a burst, a pause with the step input low, a stop alone, and a stop coinciding with a start. These show which control input takes priority.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    // Burst configuration captured at start.
    typedef struct packed {
        logic       full;   // page mode, runs until stopped
        logic       ilv;    // interleaved ordering
        logic       err;    // reserved code was given
        logic [2:0] lg;     // log2 of beat count for fixed bursts
    } burst_cfg_t;

    localparam logic [2:0] CODE_PAGE = 3'b111;

    function automatic burst_cfg_t decode_cfg(input logic [2:0] code, input logic ilv);
        burst_cfg_t c;
        c.ilv  = ilv;
        c.full = 1'b0;
        c.err  = 1'b0;
        c.lg   = 3'd0;
        if (code[2] == 1'b0) begin
            c.lg = {1'b0, code[1:0]};
        end else if (code == CODE_PAGE && !ilv) begin
            c.full = 1'b1;
        end else begin
            c.err = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/colseq_decode.sv
module colseq_decode
    import colseq_pkg::*;
(
    input  logic [2:0]  len_code_i,
    input  logic        ordering_i,
    output burst_cfg_t  cfg_o
);
    always_comb cfg_o = decode_cfg(len_code_i, ordering_i);
endmodule

// File: rtl/colseq_counter.sv
module colseq_counter
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_cfg_t       cfg_i,
    input  logic             step_i,
    input  logic             stop_i,
    output logic             active_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_o,
    output burst_cfg_t       cfg_o,
    output logic             last_o
);
    logic             active_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    burst_cfg_t       cfg_q;
    logic [COL_W-1:0] final_beat;

    always_comb begin
        final_beat = (COL_W'(1) << cfg_q.lg) - COL_W'(1);
        last_o     = active_q && !cfg_q.full && (beat_q == final_beat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            beat_q   <= '0;
            base_q   <= '0;
            cfg_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
            base_q   <= start_col_i;
            cfg_q    <= cfg_i;
        end else if (stop_i) begin
            active_q <= 1'b0;
        end else if (active_q && step_i) begin
            if (last_o) active_q <= 1'b0;
            else        beat_q   <= beat_q + COL_W'(1);
        end
    end

    assign active_o = active_q;
    assign beat_o   = beat_q;
    assign base_o   = base_q;
    assign cfg_o    = cfg_q;

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (active_q && beat_q == '0));
    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> !active_q);
    // R1
    burst_done_chk: assert property (@(posedge clk) disable iff (rst)
        (last_o && step_i && !start_i && !stop_i) |=> !active_q);
    // R8
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && !step_i && !start_i && !stop_i) |=> (active_q && $stable(beat_q)));
endmodule

// File: rtl/colseq_addrgen.sv
module colseq_addrgen
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  burst_cfg_t       cfg_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] mix;

    assign sum = base_i + beat_i;
    assign mix = base_i ^ beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        logic in_block;
        assign in_block = cfg_i.full || (int'(cfg_i.lg) > i);
        assign col_o[i] = !in_block ? base_i[i] :
                          (cfg_i.ilv ? mix[i] : sum[i]);
    end
endmodule

// File: rtl/colseq_top.sv
module colseq_top
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ordering_i,
    input  logic             step_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             err_o
);
    localparam int BLK_W = 3; // widest fixed burst is 2**BLK_W beats

    burst_cfg_t       cfg_new;
    burst_cfg_t       cfg_run;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic             active;
    logic             last_int;

    colseq_decode u_dec (
        .len_code_i (len_code_i),
        .ordering_i (ordering_i),
        .cfg_o      (cfg_new)
    );

    colseq_counter #(.COL_W(COL_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .start_col_i(start_col_i),
        .cfg_i      (cfg_new),
        .step_i     (step_i),
        .stop_i     (stop_i),
        .active_o   (active),
        .beat_o     (beat),
        .base_o     (base),
        .cfg_o      (cfg_run),
        .last_o     (last_int)
    );

    colseq_addrgen #(.COL_W(COL_W)) u_gen (
        .base_i (base),
        .beat_i (beat),
        .cfg_i  (cfg_run),
        .col_o  (col_o)
    );

    assign valid_o = active;
    assign last_o  = last_int;
    assign err_o   = active && cfg_run.err;

    // R7
    start_col_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(start_col_i)));
    // R4
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !cfg_run.full && $past(valid_o) && !$past(start_i))
        |-> $stable(col_o[COL_W-1:BLK_W]));
    // R5
    page_no_last_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && cfg_run.full) |-> !last_o);
    // R6
    reserved_single_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> last_o);
    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!valid_o && !last_o && !err_o));
endmodule

// File: tb/tb_colseq_top.sv
module tb_colseq_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i, ordering_i, step_i, stop_i;
    logic [7:0] start_col_i;
    logic [2:0] len_code_i;
    logic [7:0] col_o;
    logic       valid_o, last_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    colseq_top dut (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .len_code_i(len_code_i), .ordering_i(ordering_i), .step_i(step_i),
        .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o),
        .err_o(err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit is_rsv(input int code, input int ilv);
        return (code >= 4 && code <= 6) || (code == 7 && ilv == 1);
    endfunction

    function automatic int exp_col(input int s, input int code, input int ilv, input int b);
        int len;
        if (code == 7 && ilv == 0) return (s + b) % 256;
        if (is_rsv(code, ilv)) return s;
        len = 1 << code;
        if (ilv) return (s & ~(len - 1)) | ((s ^ b) & (len - 1));
        return (s & ~(len - 1)) | ((s + b) % len);
    endfunction

    // Start a burst, then check n beats with step held high.
    task automatic run_burst(input int s, input int code, input int ilv, input int n);
        int  len;
        bit  page;
        page = (code == 7 && ilv == 0);
        len  = is_rsv(code, ilv) ? 1 : (page ? 0 : (1 << code));
        @(negedge clk);
        start_i = 1'b1; start_col_i = 8'(s); len_code_i = 3'(code);
        ordering_i = 1'(ilv); step_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int b = 0; b < (page ? n : len); b++) begin
            chk("R7 valid", int'(valid_o), 1);
            if (page)             chk("R5 col", int'(col_o), exp_col(s, code, ilv, b));
            else if (is_rsv(code, ilv)) chk("R6 col", int'(col_o), s);
            else if (ilv)         chk("R3 col", int'(col_o), exp_col(s, code, ilv, b));
            else                  chk("R2 col", int'(col_o), exp_col(s, code, ilv, b));
            if (!page && !is_rsv(code, ilv))
                chk("R4 upper", int'(col_o) >> code, s >> code);
            chk(page ? "R5 last" : "R1 last", int'(last_o), (!page && b == len - 1) ? 1 : 0);
            chk("R6 err", int'(err_o), is_rsv(code, ilv) ? 1 : 0);
            @(negedge clk);
        end
        if (page) begin
            stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
            chk("R9 stop", int'(valid_o), 0);
        end else begin
            chk("R1 end", int'(valid_o), 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; start_col_i = '0; len_code_i = '0;
        ordering_i = 1'b0; step_i = 1'b0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 valid", int'(valid_o), 0);
        chk("R10 last", int'(last_o), 0);
        chk("R10 err", int'(err_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 idle", int'(valid_o), 0);

        // Sweep of all starts, codes and orderings
        for (int ilv = 0; ilv < 2; ilv++)
            for (int code = 0; code < 8; code++)
                for (int s = 0; s < 256; s++)
                    run_burst(s, code, ilv, 12);

        // R5 long page run across the row end
        run_burst(250, 7, 0, 300);

        // R7 restart during a running burst
        @(negedge clk);
        start_i = 1'b1; start_col_i = 8'h10; len_code_i = 3'd3; ordering_i = 1'b0; step_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 pre-restart", int'(col_o), 8'h12);
        start_i = 1'b1; start_col_i = 8'h25; len_code_i = 3'd2; ordering_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R7 restart col", int'(col_o), 8'h25);
        for (int b = 1; b < 4; b++) begin
            @(negedge clk);
            chk("R3 restart seq", int'(col_o), 8'h24 | ((5 ^ b) & 3));
        end
        chk("R1 restart last", int'(last_o), 1);
        @(negedge clk);
        chk("R1 restart end", int'(valid_o), 0);

        // R8 pause with step low
        start_i = 1'b1; start_col_i = 8'h43; len_code_i = 3'd3; ordering_i = 1'b0; step_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 first", int'(col_o), 8'h43);
        @(negedge clk);
        chk("R8 hold", int'(col_o), 8'h43);
        @(negedge clk);
        chk("R8 hold valid", int'(valid_o), 1);
        step_i = 1'b1;
        @(negedge clk);
        chk("R8 resume", int'(col_o), 8'h44);

        // R9 stop alone on a fixed burst
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R9 stop fixed", int'(valid_o), 0);

        // R9 stop together with start: start wins
        start_i = 1'b1; stop_i = 1'b1; start_col_i = 8'h9A; len_code_i = 3'd1; ordering_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        chk("R9 start wins valid", int'(valid_o), 1);
        chk("R9 start wins col", int'(col_o), 8'h9A);
        @(negedge clk);
        chk("R2 pair wrap", int'(col_o), 8'h9B);
        chk("R1 pair last", int'(last_o), 1);
        @(negedge clk);
        chk("R1 pair end", int'(valid_o), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule